// File: doc/BRIEF.md
# Security-Filtered Performance Counter Pair

This block holds two 32-bit performance counters. The event counter adds one for every clock in which an external event pulse is high. The cycle counter adds one on every clock. Each counter decides on each clock whether it may count. That decision depends on the current privilege level (0 to 3) and on the security state. Each counter has its own five-bit filter for this. Lower-privilege software programs the filters, and secure-side controls can override them.

Software uses a small read/write register port. Through it, software sets the filters, the enables for each counter, a global enable and a disable-when-prohibited bit. The same port sets a secure event permit bit and a secure cycle-disable bit, and it loads or reads the counters. An external input signals that secure non-invasive debug is allowed, and it lifts the secure prohibition. Level 3 is always treated as secure when the prohibition checks are made.

Top module: `secmon_ctr`

## Requirements
- R1: After reset, every control register and both counters read 0, and neither counter moves while the global enable is 0.
- R2: The register map is as follows (unmapped addresses read 0). Address 0 holds the global enable at bit 0 and the disable-when-prohibited bit at bit 1. Address 1 holds the event counter enable at bit 0 and the cycle counter enable at bit 1. Addresses 2 and 3 hold the event and cycle filters. Address 4 holds the secure event permit at bit 0 and the secure cycle-disable at bit 1. Address 5 is the event count and address 6 is the cycle count. A write takes effect at the next clock edge, and a read is combinational.
- R3: A counter advances only in a cycle in which its own enable bit and the global enable are both 1. The event counter adds 1 in each such cycle with the event input high. The cycle counter adds 1 in each such cycle.
- R4: The filter bits are: bit 0 for the level-1 exclude, bit 1 for the non-secure level-1 flip, bit 2 for the level-3 flip, bit 3 for the non-secure level-2 include and bit 4 for the secure level-2 flip. Level 0 always passes the filter. Secure level 1 passes when bit 0 is 0. Non-secure level 1 passes when bit 0 equals bit 1.
- R5: Non-secure level 2 passes when bit 3 is 1. Secure level 2 passes when bits 3 and 4 differ. Level 3 passes, in either state, when bit 2 equals bit 0.
- R6: The filter value 0x12 counts at secure levels 1 and 2, at level 3 and at level 0. It blocks non-secure levels 1 and 2.
- R7: In secure state or at level 3, the event counter holds when the permit bit is 0 and the debug input is low.
- R8: A high debug input lifts the prohibition of R7, and it also lifts the cycle-counter stop of R9.
- R9: Under the prohibition of R7, the cycle counter holds when the disable-when-prohibited bit is 1. It keeps counting when that bit is 0.
- R10: A secure cycle-disable of 1 stops the cycle counter in secure state and at level 3, whatever the permit, debug and disable-when-prohibited values are.
- R11: Both counters wrap from 0xFFFFFFFF to 0.
- R12: A write to a counter in a cycle where it would also increment loads exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 2 | Current privilege level |
| secure_i | input | 1 | 1 when in secure state |
| event_i | input | 1 | Event pulse, counted per high cycle |
| dbg_sec_en_i | input | 1 | Secure non-invasive debug allowed |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| evt_count_o | output | 32 | Event counter value |
| cyc_count_o | output | 32 | Cycle counter value |

## Verification
A software load of a counter and a counting increment can land on the same clock edge. The bench provokes this by writing the cycle counter and the event counter while both are enabled and counting, with the event input held high. The written value must appear exactly on the following cycle, with no extra one added. One cycle later it must have advanced by exactly one, which shows that counting resumed from the loaded value.

// File: rtl/secmon_pkg.sv
package secmon_pkg;

    localparam int NUM_CTR = 2;
    localparam int EV_IDX  = 0;
    localparam int CY_IDX  = 1;
    localparam int REG_AW  = 3;

    typedef struct packed {
        logic s_el2_flip;
        logic ns_el2_incl;
        logic el3_flip;
        logic ns_el1_flip;
        logic el1_excl;
    } filt_t;

    localparam int FILT_W = $bits(filt_t);

    typedef enum logic [REG_AW-1:0] {
        A_CTRL   = 3'd0,
        A_ENABLE = 3'd1,
        A_EVFILT = 3'd2,
        A_CYFILT = 3'd3,
        A_SECCTL = 3'd4,
        A_EVCNT  = 3'd5,
        A_CYCNT  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic                      glob_en;
        logic                      dp;
        logic [NUM_CTR-1:0]        ctr_en;
        filt_t [NUM_CTR-1:0]       filt;
        logic                      permit;
        logic                      cyc_sdis;
    } regs_t;

endpackage

// File: rtl/secmon_filter.sv
module secmon_filter
    import secmon_pkg::*;
(
    input  filt_t       filt_i,
    input  logic [1:0]  level_i,
    input  logic        secure_i,
    output logic        pass_o
);
    always_comb begin
        unique case (level_i)
            2'd0: pass_o = 1'b1;
            2'd1: pass_o = secure_i ? ~filt_i.el1_excl
                                    : ~(filt_i.el1_excl ^ filt_i.ns_el1_flip);
            2'd2: pass_o = secure_i ? (filt_i.ns_el2_incl ^ filt_i.s_el2_flip)
                                    : filt_i.ns_el2_incl;
            default: pass_o = ~(filt_i.el1_excl ^ filt_i.el3_flip);
        endcase
    end
endmodule

// File: rtl/secmon_prohibit.sv
module secmon_prohibit
    import secmon_pkg::*;
(
    input  logic [1:0]         level_i,
    input  logic               secure_i,
    input  logic               dbg_sec_en_i,
    input  logic               permit_i,
    input  logic               dp_i,
    input  logic               cyc_sdis_i,
    output logic [NUM_CTR-1:0] stop_o
);
    logic sec_eff;
    logic evt_block;

    always_comb begin
        sec_eff           = secure_i | (level_i == 2'd3);
        evt_block         = sec_eff & ~permit_i & ~dbg_sec_en_i;
        stop_o            = '0;
        stop_o[EV_IDX]    = evt_block;
        stop_o[CY_IDX]    = (evt_block & dp_i) | (sec_eff & cyc_sdis_i);
    end
endmodule

// File: rtl/secmon_counter.sv
module secmon_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/secmon_ctr.sv
module secmon_ctr
    import secmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        level_i,
    input  logic              secure_i,
    input  logic              event_i,
    input  logic              dbg_sec_en_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [CNT_W-1:0]  evt_count_o,
    output logic [CNT_W-1:0]  cyc_count_o
);
    regs_t regs_d, regs_q;

    logic [NUM_CTR-1:0]   pass;
    logic [NUM_CTR-1:0]   stop;
    logic [NUM_CTR-1:0]   inc;
    logic [NUM_CTR-1:0]   load;
    logic [CNT_W-1:0]     count [NUM_CTR];

    // control register file
    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (addr_i)
                A_CTRL: begin
                    regs_d.glob_en = wdata_i[0];
                    regs_d.dp      = wdata_i[1];
                end
                A_ENABLE: regs_d.ctr_en         = wdata_i[NUM_CTR-1:0];
                A_EVFILT: regs_d.filt[EV_IDX]   = filt_t'(wdata_i[FILT_W-1:0]);
                A_CYFILT: regs_d.filt[CY_IDX]   = filt_t'(wdata_i[FILT_W-1:0]);
                A_SECCTL: begin
                    regs_d.permit   = wdata_i[0];
                    regs_d.cyc_sdis = wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    secmon_prohibit u_prohibit (
        .level_i      (level_i),
        .secure_i     (secure_i),
        .dbg_sec_en_i (dbg_sec_en_i),
        .permit_i     (regs_q.permit),
        .dp_i         (regs_q.dp),
        .cyc_sdis_i   (regs_q.cyc_sdis),
        .stop_o       (stop)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic ok;

        secmon_filter u_filter (
            .filt_i   (regs_q.filt[g]),
            .level_i  (level_i),
            .secure_i (secure_i),
            .pass_o   (pass[g])
        );

        assign ok = regs_q.glob_en & regs_q.ctr_en[g] & pass[g] & ~stop[g];

        if (g == EV_IDX) begin : g_evt
            assign inc[g]  = ok & event_i;
            assign load[g] = wr_en_i & (addr_i == A_EVCNT);
        end else begin : g_cyc
            assign inc[g]  = ok;
            assign load[g] = wr_en_i & (addr_i == A_CYCNT);
        end

        secmon_counter #(.CNT_W(CNT_W)) u_counter (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .inc_i      (inc[g]),
            .load_i     (load[g]),
            .load_val_i (wdata_i),
            .count_o    (count[g])
        );
    end

    assign evt_count_o = count[EV_IDX];
    assign cyc_count_o = count[CY_IDX];

    // read mux
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[0] = regs_q.glob_en;
                rdata_o[1] = regs_q.dp;
            end
            A_ENABLE: rdata_o[NUM_CTR-1:0] = regs_q.ctr_en;
            A_EVFILT: rdata_o[FILT_W-1:0]  = regs_q.filt[EV_IDX];
            A_CYFILT: rdata_o[FILT_W-1:0]  = regs_q.filt[CY_IDX];
            A_SECCTL: begin
                rdata_o[0] = regs_q.permit;
                rdata_o[1] = regs_q.cyc_sdis;
            end
            A_EVCNT: rdata_o = count[EV_IDX];
            A_CYCNT: rdata_o = count[CY_IDX];
            default: ;
        endcase
    end
endmodule

// File: rtl/secmon_ctr_chk.sv
module secmon_ctr_chk
    import secmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        level,
    input logic              secure,
    input logic              dbg,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              glob_en,
    input logic              permit,
    input logic              cyc_sdis,
    input logic [CNT_W-1:0]  evt_cnt,
    input logic [CNT_W-1:0]  cyc_cnt
);
    logic sec_eff;
    assign sec_eff = secure | (level == 2'd3);

    // R3
    evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_EVCNT) |=>
            (evt_cnt == $past(evt_cnt) || evt_cnt == $past(evt_cnt) + 1'b1));

    // R1
    glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !wr_en) |=> ($stable(evt_cnt) && $stable(cyc_cnt)));

    // R7
    evt_prohibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_eff && !permit && !dbg && !wr_en) |=> $stable(evt_cnt));

    // R10
    cyc_sdis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_eff && cyc_sdis && !wr_en) |=> $stable(cyc_cnt));

    // R12
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CYCNT) |=> (cyc_cnt == $past(wdata)));
endmodule

bind secmon_ctr secmon_ctr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .level    (level_i),
    .secure   (secure_i),
    .dbg      (dbg_sec_en_i),
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .wdata    (wdata_i),
    .glob_en  (regs_q.glob_en),
    .permit   (regs_q.permit),
    .cyc_sdis (regs_q.cyc_sdis),
    .evt_cnt  (evt_count_o),
    .cyc_cnt  (cyc_count_o)
);

// File: tb/secmon_ctr_test.sv
`timescale 1ns/1ps
module secmon_ctr_test;
    import secmon_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  level = 2'd0;
    logic        secure = 1'b0;
    logic        event_in = 1'b0;
    logic        dbg = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata, evt_cnt, cyc_cnt;

    int checks = 0;
    int errors = 0;
    logic tb_dp = 1'b0;

    always #2.5 clk = ~clk;

    secmon_ctr uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .level_i      (level),
        .secure_i     (secure),
        .event_i      (event_in),
        .dbg_sec_en_i (dbg),
        .wr_en_i      (wr_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .evt_count_o  (evt_cnt),
        .cyc_count_o  (cyc_cnt)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic setup(input logic [4:0] evf, input logic [4:0] cyf,
                         input logic [1:0] en, input logic [1:0] sec, input logic dp);
        tb_dp = dp;
        wr(A_CTRL, {30'd0, dp, 1'b0});
        wr(A_EVFILT, {27'd0, evf});
        wr(A_CYFILT, {27'd0, cyf});
        wr(A_ENABLE, {30'd0, en});
        wr(A_SECCTL, {30'd0, sec});
    endtask

    // counts during one enabled window: cycle count = n + 1, event = ones in pat
    task automatic window(input int n, input logic [15:0] pat,
                          input logic [31:0] ev0, input logic [31:0] cy0,
                          output logic [31:0] ev, output logic [31:0] cy);
        wr(A_EVCNT, ev0);
        wr(A_CYCNT, cy0);
        wr(A_CTRL, {30'd0, tb_dp, 1'b1});
        for (int i = 0; i < n; i++) begin
            event_in = pat[i];
            @(negedge clk);
        end
        event_in = 1'b0;
        wr(A_CTRL, {30'd0, tb_dp, 1'b0});
        rd(A_EVCNT, ev);
        rd(A_CYCNT, cy);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R1 reset readback", v, 32'd0);
        end
        event_in = 1'b1;
        repeat (10) @(negedge clk);
        event_in = 1'b0;
        check("R1 event idle", evt_cnt, 32'd0);
        check("R1 cycle idle", cyc_cnt, 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        setup(5'h15, 5'h0A, 2'b10, 2'b11, 1'b1);
        rd(A_CTRL, v);   check("R2 ctrl readback", v, 32'h2);
        rd(A_ENABLE, v); check("R2 enable readback", v, 32'h2);
        rd(A_EVFILT, v); check("R2 event filter readback", v, 32'h15);
        rd(A_CYFILT, v); check("R2 cycle filter readback", v, 32'h0A);
        rd(A_SECCTL, v); check("R2 secure ctl readback", v, 32'h3);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, v);     check("R2 unmapped reads zero", v, 32'd0);
    endtask

    task automatic t_enables();
        logic [31:0] ev, cy;
        level = 2'd0; secure = 1'b0; dbg = 1'b0;
        setup(5'h0, 5'h0, 2'b11, 2'b01, 1'b0);
        window(8, 16'b0100_1101, 0, 0, ev, cy);
        check("R3 event counts high cycles", ev, 32'd4);
        check("R3 cycle counts every cycle", cy, 32'd9);
        setup(5'h0, 5'h0, 2'b01, 2'b01, 1'b0);
        window(5, 16'hFFFF, 0, 0, ev, cy);
        check("R3 event only enabled", ev, 32'd5);
        check("R3 cycle disabled", cy, 32'd0);
        setup(5'h0, 5'h0, 2'b10, 2'b01, 1'b0);
        window(5, 16'hFFFF, 0, 0, ev, cy);
        check("R3 event disabled", ev, 32'd0);
        check("R3 cycle only enabled", cy, 32'd6);
    endtask

    task automatic t_filters();
        logic [31:0] ev, cy;
        logic ok;
        dbg = 1'b0;
        for (int cfg = 0; cfg < 2; cfg++) begin
            setup(cfg == 0 ? 5'h12 : 5'h1B, cfg == 0 ? 5'h12 : 5'h1B, 2'b11, 2'b01, 1'b0);
            for (int l = 0; l < 4; l++) begin
                for (int s = 0; s < 2; s++) begin
                    level = l[1:0]; secure = s[0];
                    if (l == 0) ok = 1'b1;
                    else if (cfg == 0) ok = (l == 3) || (s == 1);
                    else ok = (l != 3) && (s == 0);
                    window(4, 16'hFFFF, 0, 0, ev, cy);
                    if (cfg == 0) begin
                        check($sformatf("R6 event lvl%0d sec%0d", l, s), ev, ok ? 32'd4 : 32'd0);
                        check($sformatf("R6 cycle lvl%0d sec%0d", l, s), cy, ok ? 32'd5 : 32'd0);
                    end else if (l == 1) begin
                        check($sformatf("R4 event lvl1 sec%0d", s), ev, ok ? 32'd4 : 32'd0);
                        check($sformatf("R4 cycle lvl1 sec%0d", s), cy, ok ? 32'd5 : 32'd0);
                    end else begin
                        check($sformatf("R5 event lvl%0d sec%0d", l, s), ev, ok ? 32'd4 : 32'd0);
                        check($sformatf("R5 cycle lvl%0d sec%0d", l, s), cy, ok ? 32'd5 : 32'd0);
                    end
                end
            end
        end
    endtask

    task automatic t_prohibit();
        logic [31:0] ev, cy;
        dbg = 1'b0;
        level = 2'd1; secure = 1'b1;
        setup(5'h0, 5'h0, 2'b11, 2'b00, 1'b0);
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R7 secure event held", ev, 32'd0);
        check("R9 cycle runs with dp 0", cy, 32'd7);
        setup(5'h0, 5'h0, 2'b11, 2'b00, 1'b1);
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R7 secure event held dp 1", ev, 32'd0);
        check("R9 cycle held with dp 1", cy, 32'd0);
        level = 2'd3; secure = 1'b0;
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R7 level 3 event held", ev, 32'd0);
        check("R9 level 3 cycle held", cy, 32'd0);
        level = 2'd1; secure = 1'b0;
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R7 non-secure event counts", ev, 32'd6);
        check("R9 non-secure cycle counts", cy, 32'd7);
    endtask

    task automatic t_debug();
        logic [31:0] ev, cy;
        level = 2'd1; secure = 1'b1; dbg = 1'b1;
        setup(5'h0, 5'h0, 2'b11, 2'b00, 1'b1);
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R8 debug lifts event prohibit", ev, 32'd6);
        check("R8 debug lifts cycle stop", cy, 32'd7);
        dbg = 1'b0;
    endtask

    task automatic t_sdis();
        logic [31:0] ev, cy;
        level = 2'd1; secure = 1'b1; dbg = 1'b1;
        setup(5'h0, 5'h0, 2'b11, 2'b11, 1'b0);
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R10 secure event still counts", ev, 32'd6);
        check("R10 secure cycle stopped", cy, 32'd0);
        level = 2'd3; secure = 1'b0;
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R10 level 3 cycle stopped", cy, 32'd0);
        level = 2'd1; secure = 1'b0;
        window(6, 16'hFFFF, 0, 0, ev, cy);
        check("R10 non-secure cycle counts", cy, 32'd7);
        dbg = 1'b0;
    endtask

    task automatic t_wrap();
        logic [31:0] ev, cy;
        level = 2'd0; secure = 1'b0;
        setup(5'h0, 5'h0, 2'b11, 2'b01, 1'b0);
        window(2, 16'h0001, 32'hFFFF_FFFF, 32'hFFFF_FFFE, ev, cy);
        check("R11 event wraps", ev, 32'd0);
        check("R11 cycle wraps", cy, 32'd1);
    endtask

    task automatic t_collide();
        level = 2'd0; secure = 1'b0;
        setup(5'h0, 5'h0, 2'b11, 2'b01, 1'b0);
        event_in = 1'b1;
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        wr(A_CYCNT, 32'h100);
        check("R12 cycle load wins", cyc_cnt, 32'h100);
        @(negedge clk);
        check("R12 cycle resumes", cyc_cnt, 32'h101);
        wr(A_EVCNT, 32'h200);
        check("R12 event load wins", evt_cnt, 32'h200);
        @(negedge clk);
        check("R12 event resumes", evt_cnt, 32'h201);
        event_in = 1'b0;
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_enables();
        t_filters();
        t_prohibit();
        t_debug();
        t_sdis();
        t_wrap();
        t_collide();
        summary();
        $finish;
    end
endmodule